// File: doc/BRIEF.md
# Polled Real-Time-Clock Interrupt Event Generator

This block turns one fixed-rate polling tick into the three interrupt kinds a real-time clock offers: an update event once per new second, an alarm event when the time of day equals a programmed value, and a periodic event at a selectable power-of-two rate. A one-shot timer channel supplies the tick. The block owns that channel's compare value. Each time the channel fires, the block moves the compare value forward by the tick delta until it lies ahead of the free-running counter. Ticks that were missed along the way are counted as lost and are folded into the periodic divider.

The periodic rate is given as a code k, which asks for 2^k Hz. The polling rate is 2^BASE_LOG2 Hz, which is 64 Hz by default. For rates at or below the polling rate, the block divides the tick by 2^(BASE_LOG2-k). For faster rates, it shortens the tick delta to the requested period and raises a periodic event on every tick. Clearing every enable stops the channel. Turning the first enable on again re-arms the channel one delta past the current counter.

The event output is a single-cycle strobe with a status word. There is no back-pressure: a consumer that needs the word must capture it in the strobe cycle, and the word holds its value until the next event. Control inputs and status outputs are plain levels.

Top module: `rtcev_gen`

## Requirements
- R1: During and after reset `irq_o` is low, `armed_o` is low, and `cmp_o`, `evt_word_o` and `lost_total_o` are zero.
- R2: In the cycle after any enable rises while all three were clear, `armed_o` goes high and `cmp_o` equals `count_i` plus the active delta. In the cycle after all enables are clear, `armed_o` is low. A tick while disarmed produces no event and leaves `cmp_o` unchanged.
- R3: For a rate code k of at most BASE_LOG2, the divider limit is 2^(BASE_LOG2-k) and the active delta is `base_delta_i`. For k above BASE_LOG2 with periodic enabled, the limit is zero and the active delta is `base_delta_i >> (k-BASE_LOG2)`.
- R4: On each serviced tick with periodic enabled, the periodic count becomes count + lost + 1. When that value is at least the limit, a periodic event is raised and the count returns to 0. Clearing the periodic enable zeroes the count.
- R5: With update enabled, an update event is raised when `sec_i` differs from the stored previous second. The first serviced tick after the update enable rises raises no update event and only stores the second.
- R6: With alarm enabled, an alarm event is raised on a serviced tick where hour, minute and second all equal the alarm inputs.
- R7: On an accepted tick, the compare value is advanced by the delta, and then again once per cycle while `count_i - cmp` (taken as a signed 32-bit value) is not negative. Each advance beyond the first is one lost tick. This holds across 32-bit wrap-around.
- R8: `lost_total_o` accumulates the lost ticks, saturates at its all-ones value, and never decreases.
- R9: A serviced tick that raises any event pulses `irq_o` for exactly one cycle. `evt_word_o` then carries bit 0 for periodic, bit 1 for alarm, bit 2 for update, bit 7 as the pending flag, and the value 1 in bits 15:8. A serviced tick that raises no event gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe: the timer channel fired |
| count_i | input | 32 | Free-running channel counter |
| base_delta_i | input | 32 | Counter ticks per polling period |
| hour_i | input | TIME_W | Current hour |
| min_i | input | TIME_W | Current minute |
| sec_i | input | TIME_W | Current second |
| en_update_i | input | 1 | Update event enable |
| en_alarm_i | input | 1 | Alarm event enable |
| en_periodic_i | input | 1 | Periodic event enable |
| alarm_hour_i | input | TIME_W | Alarm hour |
| alarm_min_i | input | TIME_W | Alarm minute |
| alarm_sec_i | input | TIME_W | Alarm second |
| rate_code_i | input | CODE_W | Periodic rate code k, asks for 2^k Hz |
| irq_o | output | 1 | One-cycle interrupt strobe |
| evt_word_o | output | 16 | Event status word |
| cmp_o | output | 32 | Channel compare value |
| armed_o | output | 1 | Channel is enabled |
| lost_total_o | output | LOST_W | Saturating lost-tick total |

## Verification
On a single serviced tick, the update, alarm and periodic decisions are all made in the same cycle. The bench sets the periodic rate above the polling rate so that every tick is periodic, puts the alarm on the next second, and ticks twice. The first tick gives only the periodic bit, because the update stage is only storing its first second. The second tick must give one strobe whose word holds all three flags. A separate case forces the periodic divider to finish early on a tick that also adds lost ticks; the expected periodic count there is computed from the stepping arithmetic.

// File: rtl/rtcev_pkg.sv
package rtcev_pkg;
  localparam int FLAG_PER  = 0;
  localparam int FLAG_ALM  = 1;
  localparam int FLAG_UPD  = 2;
  localparam int FLAG_PEND = 7;

  // true when compare value c still lies ahead of counter now
  function automatic logic cnt_ahead(input logic [31:0] c, input logic [31:0] now);
    logic [31:0] diff;
    diff = now - c;
    return diff[31];
  endfunction
endpackage

// File: rtl/rtcev_rate.sv
module rtcev_rate #(
  parameter int CODE_W    = 4,
  parameter int LIM_W     = 8,
  parameter int BASE_LOG2 = 6
) (
  input  logic [31:0]       base_delta,
  input  logic [CODE_W-1:0] code,
  input  logic              per_en,
  output logic [LIM_W-1:0]  limit,
  output logic [31:0]       delta
);
  localparam logic [CODE_W-1:0] BASE_CODE = CODE_W'(BASE_LOG2);

  logic [31:0] fast;
  always_comb begin
    limit = '0;
    fast  = base_delta;
    if (code <= BASE_CODE) limit = LIM_W'(1) << (BASE_LOG2 - int'(code));
    else                   fast  = base_delta >> (int'(code) - BASE_LOG2);
    delta = (per_en && code > BASE_CODE) ? fast : base_delta;
  end
endmodule

// File: rtl/rtcev_rearm.sv
module rtcev_rearm #(
  parameter int STEP_W = 8,
  parameter int LOST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_any,
  input  logic              tick,
  input  logic [31:0]       count,
  input  logic [31:0]       delta,
  output logic [31:0]       cmp,
  output logic              armed,
  output logic              done,
  output logic [STEP_W-1:0] lost_n,
  output logic [LOST_W-1:0] lost_total
);
  import rtcev_pkg::*;
  localparam int SUM_W = ((LOST_W > STEP_W) ? LOST_W : STEP_W) + 1;
  localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};
  localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

  typedef enum logic {ST_IDLE, ST_STEP} st_t;
  st_t st;
  logic prev_any;
  logic [STEP_W-1:0] steps;
  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(lost_total) + SUM_W'(steps);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; prev_any <= 1'b0; armed <= 1'b0; done <= 1'b0;
      cmp <= '0; steps <= '0; lost_n <= '0; lost_total <= '0;
    end else begin
      prev_any <= en_any;
      done     <= 1'b0;
      if (!en_any) begin
        armed <= 1'b0;
        st    <= ST_IDLE;
      end else if (!prev_any) begin
        armed <= 1'b1;
        cmp   <= count + delta;
        st    <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (tick && armed) begin
            cmp   <= cmp + delta;
            steps <= '0;
            st    <= ST_STEP;
          end
          ST_STEP: if (cnt_ahead(cmp, count) || steps == STEP_MAX) begin
            done       <= 1'b1;
            lost_n     <= steps;
            lost_total <= (sum > SUM_W'(LOST_MAX)) ? LOST_MAX : LOST_W'(sum);
            st         <= ST_IDLE;
          end else begin
            cmp   <= cmp + delta;
            steps <= steps + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_disarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any |=> !armed);
  assert_arm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_any && !prev_any) |=> (armed && cmp == $past(count) + $past(delta)));
  assert_lost_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_total >= $past(lost_total));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rtcev_events.sv
module rtcev_events #(
  parameter int TIME_W = 8,
  parameter int LIM_W  = 8,
  parameter int STEP_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [STEP_W-1:0] lost_n,
  input  logic              en_u,
  input  logic              en_a,
  input  logic              en_p,
  input  logic [TIME_W-1:0] hour,
  input  logic [TIME_W-1:0] minute,
  input  logic [TIME_W-1:0] sec,
  input  logic [TIME_W-1:0] a_hour,
  input  logic [TIME_W-1:0] a_min,
  input  logic [TIME_W-1:0] a_sec,
  input  logic [LIM_W-1:0]  limit,
  output logic              evt_valid,
  output logic [15:0]       evt_word
);
  import rtcev_pkg::*;
  localparam logic [TIME_W-1:0] SEC_NONE = {TIME_W{1'b1}};

  logic prev_u;
  logic [TIME_W-1:0] prev_sec;
  logic [CNT_W-1:0] pie_cnt, pie_next;
  logic fresh_u, hit_u, hit_a, hit_p;

  always_comb begin
    fresh_u  = en_u && !prev_u;
    pie_next = pie_cnt + CNT_W'(lost_n) + 1'b1;
    hit_p    = en_p && (pie_next >= CNT_W'(limit));
    hit_a    = en_a && hour == a_hour && minute == a_min && sec == a_sec;
    hit_u    = en_u && !fresh_u && prev_sec != SEC_NONE && sec != prev_sec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_u <= 1'b0; prev_sec <= SEC_NONE; pie_cnt <= '0;
      evt_valid <= 1'b0; evt_word <= '0;
    end else begin
      prev_u    <= en_u;
      evt_valid <= 1'b0;
      if (fresh_u) prev_sec <= SEC_NONE;
      else if (done && en_u && sec != prev_sec) prev_sec <= sec;
      if (!en_p) pie_cnt <= '0;
      else if (done) pie_cnt <= hit_p ? '0 : pie_next;
      if (done && (hit_u || hit_a || hit_p)) begin
        evt_valid <= 1'b1;
        evt_word  <= '0;
        evt_word[15:8]    <= 8'd1;
        evt_word[FLAG_PEND] <= 1'b1;
        evt_word[FLAG_PER]  <= hit_p;
        evt_word[FLAG_ALM]  <= hit_a;
        evt_word[FLAG_UPD]  <= hit_u;
      end
    end
  end

  assert_word_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_word[15:8] == 8'd1 && evt_word[FLAG_PEND] && (|evt_word[2:0])));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  assert_strobe_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(done));
  assert_alarm_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_word[FLAG_ALM]) |-> $past(en_a));
endmodule

// File: rtl/rtcev_gen.sv
module rtcev_gen #(
  parameter int TIME_W    = 8,
  parameter int CODE_W    = 4,
  parameter int LIM_W     = 8,
  parameter int STEP_W    = 8,
  parameter int LOST_W    = 16,
  parameter int BASE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [31:0]       count_i,
  input  logic [31:0]       base_delta_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic              en_update_i,
  input  logic              en_alarm_i,
  input  logic              en_periodic_i,
  input  logic [TIME_W-1:0] alarm_hour_i,
  input  logic [TIME_W-1:0] alarm_min_i,
  input  logic [TIME_W-1:0] alarm_sec_i,
  input  logic [CODE_W-1:0] rate_code_i,
  output logic              irq_o,
  output logic [15:0]       evt_word_o,
  output logic [31:0]       cmp_o,
  output logic              armed_o,
  output logic [LOST_W-1:0] lost_total_o
);
  localparam int CNT_W = (STEP_W > LIM_W ? STEP_W : LIM_W) + 2;

  logic [LIM_W-1:0]  limit;
  logic [31:0]       delta;
  logic              done;
  logic [STEP_W-1:0] lost_n;
  logic              en_any;

  assign en_any = en_update_i | en_alarm_i | en_periodic_i;

  rtcev_rate #(.CODE_W(CODE_W), .LIM_W(LIM_W), .BASE_LOG2(BASE_LOG2)) u_rate (
    .base_delta(base_delta_i), .code(rate_code_i), .per_en(en_periodic_i),
    .limit(limit), .delta(delta));

  rtcev_rearm #(.STEP_W(STEP_W), .LOST_W(LOST_W)) u_rearm (
    .clk(clk), .rst_n(rst_n), .en_any(en_any), .tick(tick_i), .count(count_i),
    .delta(delta), .cmp(cmp_o), .armed(armed_o), .done(done), .lost_n(lost_n),
    .lost_total(lost_total_o));

  rtcev_events #(.TIME_W(TIME_W), .LIM_W(LIM_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_events (
    .clk(clk), .rst_n(rst_n), .done(done), .lost_n(lost_n),
    .en_u(en_update_i), .en_a(en_alarm_i), .en_p(en_periodic_i),
    .hour(hour_i), .minute(min_i), .sec(sec_i),
    .a_hour(alarm_hour_i), .a_min(alarm_min_i), .a_sec(alarm_sec_i),
    .limit(limit), .evt_valid(irq_o), .evt_word(evt_word_o));
endmodule

// File: tb/rtcev_gen_test.sv
`timescale 1ns/1ps
module rtcev_gen_test;
  localparam int LW = 4;
  localparam int BASE = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [31:0] count_i = '0;
  logic [31:0] base_delta_i = BASE;
  logic [7:0] hour_i = 8'd1, min_i = 8'd2, sec_i = 8'd3;
  logic en_u = 1'b0, en_a = 1'b0, en_p = 1'b0;
  logic [7:0] ah = 8'd1, am = 8'd2, as_ = 8'd40;
  logic [3:0] code = 4'd0;
  logic irq_o, armed_o;
  logic [15:0] evt_word_o;
  logic [31:0] cmp_o;
  logic [LW-1:0] lost_total_o;

  rtcev_gen #(.LOST_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_i(count_i),
    .base_delta_i(base_delta_i), .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
    .en_update_i(en_u), .en_alarm_i(en_a), .en_periodic_i(en_p),
    .alarm_hour_i(ah), .alarm_min_i(am), .alarm_sec_i(as_), .rate_code_i(code),
    .irq_o(irq_o), .evt_word_o(evt_word_o), .cmp_o(cmp_o), .armed_o(armed_o),
    .lost_total_o(lost_total_o));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, pulses = 0;
  logic [15:0] last_word;
  logic [31:0] m_cmp = '0;
  logic m_armed = 1'b0;
  int m_prev = -1, m_pie = 0, m_lost = 0;
  bit done_flag = 0;

  always @(negedge clk) if (rst_n && irq_o) begin pulses++; last_word = evt_word_o; end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int k);
    return (k <= 6) ? (1 << (6 - k)) : 0;
  endfunction
  function automatic logic [31:0] delta_of(input bit p, input int k);
    return (p && k > 6) ? (BASE >> (k - 6)) : BASE;
  endfunction

  task automatic set_en(input bit u, input bit a, input bit p);
    bit old_any, new_any;
    old_any = en_u | en_a | en_p;
    new_any = u | a | p;
    @(negedge clk);
    if (u && !en_u) m_prev = -1;
    if (!p) m_pie = 0;
    en_u = u; en_a = a; en_p = p;
    if (new_any && !old_any) begin m_armed = 1; m_cmp = count_i + delta_of(p, int'(code)); end
    if (!new_any) m_armed = 0;
    repeat (2) @(negedge clk);
    check("R2 armed", armed_o, m_armed);
    check("R2 compare", cmp_o, m_cmp);
  endtask

  task automatic do_tick(input logic [31:0] cnt, input logic [7:0] s);
    logic [31:0] d, c;
    int lost, nxt;
    bit hp, ha, hu;
    logic [15:0] w;
    d = delta_of(en_p, int'(code));
    lost = 0; hp = 0; ha = 0; hu = 0;
    if (m_armed) begin
      c = m_cmp + d;
      while (!(($signed(cnt - c)) < 0) && lost < 255) begin c = c + d; lost++; end
      m_cmp = c;
      m_lost = (m_lost + lost > (1 << LW) - 1) ? (1 << LW) - 1 : m_lost + lost;
      if (en_p) begin
        nxt = m_pie + lost + 1;
        hp = nxt >= lim_of(int'(code));
        m_pie = hp ? 0 : nxt;
      end
      ha = en_a && hour_i == ah && min_i == am && s == as_;
      if (en_u) begin
        hu = (m_prev != -1) && (int'(s) != m_prev);
        m_prev = int'(s);
      end
    end
    @(negedge clk);
    pulses = 0;
    count_i = cnt; sec_i = s; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (lost + 8) @(negedge clk);
    w = {8'd1, 1'b1, 4'd0, hu, ha, hp};
    if (hp || ha || hu) begin
      check("R9 one strobe", pulses, 1);
      check("R4 R5 R6 R9 event word", last_word, w);
    end else check("R9 no strobe", pulses, 0);
    check("R7 compare stepping", cmp_o, m_cmp);
    check("R8 lost total", lost_total_o, m_lost);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq reset", irq_o, 0);
    check("R1 armed reset", armed_o, 0);
    check("R1 compare reset", cmp_o, 0);
    check("R1 word reset", evt_word_o, 0);
    check("R1 lost reset", lost_total_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {irq_o, armed_o}, 0);

    // R2: disarmed tick ignored
    do_tick(32'd500, 8'd3);

    // R3 R4: sweep rate codes
    for (int k = 0; k <= 9; k++) begin
      set_en(0, 0, 0);
      code = 4'(k);
      count_i = 32'd100 * k;
      set_en(0, 0, 1);
      for (int t = 0; t < ((k <= 6) ? 2 * lim_of(k) : 3); t++) do_tick(m_cmp, 8'd3);
    end

    // R5: update events
    set_en(0, 0, 0);
    set_en(1, 0, 0);
    do_tick(m_cmp, 8'd5);
    do_tick(m_cmp, 8'd5);
    do_tick(m_cmp, 8'd6);
    do_tick(m_cmp, 8'd9);

    // R6: alarm match and mismatch
    set_en(0, 0, 0);
    set_en(0, 1, 0);
    do_tick(m_cmp, 8'd40);
    min_i = 8'd7;
    do_tick(m_cmp, 8'd40);
    min_i = 8'd2;
    do_tick(m_cmp, 8'd39);

    // R7 R4: lost ticks fold into periodic count
    set_en(0, 0, 0);
    code = 4'd3;
    set_en(0, 0, 1);
    do_tick(m_cmp, 8'd3);
    do_tick(m_cmp + 3 * BASE + 5, 8'd3);
    do_tick(m_cmp, 8'd3);
    do_tick(m_cmp + 2 * BASE, 8'd3);
    do_tick(m_cmp, 8'd3);

    // R8: saturation
    do_tick(m_cmp + 20 * BASE, 8'd3);
    do_tick(m_cmp + 2 * BASE, 8'd3);

    // R7: 32-bit wrap
    set_en(0, 0, 0);
    count_i = 32'hFFFF_FE00;
    set_en(0, 0, 1);
    do_tick(m_cmp, 8'd3);
    do_tick(m_cmp + BASE + 1, 8'd3);

    // R9: update, alarm and periodic in the same tick
    set_en(0, 0, 0);
    code = 4'd8;
    as_ = 8'd11;
    set_en(1, 1, 1);
    do_tick(m_cmp, 8'd10);
    do_tick(m_cmp, 8'd11);

    // R2: disable stops channel
    set_en(0, 0, 0);
    do_tick(m_cmp + 5, 8'd12);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule